// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the floating-point status and control word of a processor core. Each cycle, the FPU datapath may present one update. The update carries an operation class, a vector of freshly detected exception conditions, the fraction-rounded and fraction-inexact indications, a five-bit result class and a selector. The unit folds the update into the register under sticky-bit rules. It keeps the derived summary bits consistent and forces the reserved position to zero. It also decides, in the same cycle, whether the instruction's destination register may be written.

The update stream has no back-pressure. The unit accepts an update on every cycle in which `upd_valid_i` is high, and there is no ready signal. The write-enable and the copied condition field are combinational responses to the update that is currently presented. The register itself changes at the next rising clock edge. Software-visible operations work on single bits, selected by `sel_i` as a bit index. The copy operation works on four-bit fields, selected by `sel_i[2:0]`.

Register layout, with bit numbers counted from the LSB:
- 31: any-exception summary.
- 30: enabled-exception summary.
- 29: invalid summary.
- 28: overflow.
- 27: underflow.
- 26: zero-divide.
- 25: inexact.
- 24..16: invalid causes, in the order signalling-NaN, inf-inf, inf/inf, 0/0, inf*0, invalid compare, software request, invalid square root, invalid convert.
- 15..12: class bits 3..0.
- 11: fraction rounded.
- 10: fraction inexact.
- 9: reserved.
- 8: class bit 4.
- 7: invalid enable.
- 6: overflow enable.
- 5: underflow enable.
- 4: zero-divide enable.
- 3: inexact enable.
- 2..0: mode bits, written only by set/clear.

Top module: `fpstat_unit`

## Requirements
- R1: After reset, the register reads 0x00000000, and `wr_en_o` and `cr_valid_o` are 0 while no update is valid.
- R2: An arithmetic update (op 0) ORs `exc_i[12:0]` into bits 28..16 and never clears them. It replaces bits 11 and 10 with `frac_rnd_i`/`frac_inx_i`, bits 15..12 with `cls_i[3:0]` and bit 8 with `cls_i[4]`.
- R3: Bit 31 is set when an update takes any of bits 28..16 from 0 to 1. Re-reporting an exception that is already set leaves bit 31 as it was.
- R4: After every update, bit 29 equals the OR of the nine invalid causes in bits 24..16. A direct set or clear of bit 29 has no lasting effect.
- R5: After every update, bit 30 equals (29&7)|(28&6)|(27&5)|(26&4)|(25&3). A direct set or clear of bit 30 has no lasting effect.
- R6: Bit 9 always reads 0, including after a set-bit operation that targets it.
- R7: A copy operation (op 4) drives `cr_valid_o`=1 and `cr_field_o` = bits [4k+3:4k] for k=`sel_i[2:0]`, with the reserved position read as 0. At the clock edge it clears bit 31 and bits 28..16 wherever they fall inside that field.
- R8: `wr_en_o` is 1 in the same cycle for a valid arithmetic update. The exception is when one of `exc_i[8:0]` is set while bit 7 is 1, or `exc_i[10]` is set while bit 4 is 1; then `wr_en_o` is 0. Overflow, underflow and inexact never suppress the write.
- R9: A move-type update (op 1) drives `wr_en_o`=1 and leaves the register unchanged, whatever `exc_i` carries.
- R10: An arithmetic update with `trivial_i`=1 clears bits 11 and 10, regardless of `frac_rnd_i` and `frac_inx_i`.
- R11: Set-bit (op 2) writes 1 to bit `sel_i`. When that takes an exception bit in 28..16 from 0 to 1, bit 31 is also set.
- R12: Clear-bit (op 3) writes 0 to bit `sel_i`, including bit 31 and the enable bits.
- R13: With `upd_valid_i`=0, or with an op code of 5..7, the register does not change and `wr_en_o` and `cr_valid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid_i | input | 1 | Update present this cycle |
| upd_op_i | input | 3 | 0 arith, 1 move, 2 set bit, 3 clear bit, 4 copy field |
| exc_i | input | 13 | New exceptions: [12] ovf, [11] unf, [10] zdiv, [9] inexact, [8:0] invalid causes |
| frac_rnd_i | input | 1 | Fraction was rounded |
| frac_inx_i | input | 1 | Fraction is inexact |
| cls_i | input | 5 | Result class |
| trivial_i | input | 1 | Result decided without computation |
| sel_i | input | 5 | Bit index, or field index in [2:0] |
| fps_o | output | 32 | Register value |
| exc_sum_o | output | 1 | Any-exception summary (bit 31) |
| en_sum_o | output | 1 | Enabled-exception summary (bit 30) |
| inv_sum_o | output | 1 | Invalid summary (bit 29) |
| cr_field_o | output | 4 | Copied field |
| cr_valid_o | output | 1 | Copy operation presented |
| wr_en_o | output | 1 | Destination register write enable |

## Verification
The hardest case to reach from the ports is the sticky-edge rule for bit 31. An exception that is reported again while it is already set must leave bit 31 alone. Because bit 31 is normally already 1 at that point, the rule can only be seen once software has cleared bit 31. The vector table therefore raises inexact, clears bit 31 with a clear-bit operation, and reports inexact again. It repeats the same pattern with a set-bit operation on an invalid cause.

Write suppression likewise needs the matching enable set before the faulting update. The table sets the invalid and zero-divide enables first, then presents a zero-divide update and an invalid update. It then presents an overflow update that must still write.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

  localparam int REG_W     = 32;
  localparam int EXC_W     = 13;
  localparam int CLS_W     = 5;
  localparam int SEL_W     = 5;
  localparam int OP_W      = 3;

  localparam int B_EXC_SUM = 31;
  localparam int B_EN_SUM  = 30;
  localparam int B_INV_SUM = 29;
  localparam int B_OVF     = 28;
  localparam int B_UNF     = 27;
  localparam int B_ZDIV    = 26;
  localparam int B_INX     = 25;
  localparam int B_INV_HI  = 24;
  localparam int B_INV_LO  = 16;
  localparam int B_CLS_HI  = 15;
  localparam int B_CLS_LO  = 12;
  localparam int B_FR      = 11;
  localparam int B_FI      = 10;
  localparam int B_RSV     = 9;
  localparam int B_CLS4    = 8;
  localparam int B_INV_EN  = 7;
  localparam int B_OVF_EN  = 6;
  localparam int B_UNF_EN  = 5;
  localparam int B_ZDIV_EN = 4;
  localparam int B_INX_EN  = 3;

  localparam int EXC_LO    = B_INV_LO;
  localparam int EXC_HI    = B_OVF;
  localparam int N_INV     = B_INV_HI - B_INV_LO + 1;
  localparam int XI_ZDIV   = B_ZDIV - EXC_LO;

  // exception bits that a copy operation clears
  localparam logic [REG_W-1:0] EXC_MASK =
    (REG_W'(1) << B_EXC_SUM) | (((REG_W'(1) << EXC_W) - REG_W'(1)) << EXC_LO);
  localparam logic [REG_W-1:0] RSV_MASK = REG_W'(1) << B_RSV;

  typedef enum logic [OP_W-1:0] {
    OP_ARITH = 3'd0,
    OP_MOVE  = 3'd1,
    OP_SETB  = 3'd2,
    OP_CLRB  = 3'd3,
    OP_COPYF = 3'd4
  } upd_op_e;

endpackage

// File: rtl/fpstat_crsel.sv
module fpstat_crsel
  import fpstat_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int N_FIELDS = 8
) (
  input  logic [FIELD_W*N_FIELDS-1:0]  cur_i,
  input  logic [$clog2(N_FIELDS)-1:0]  fsel_i,
  output logic [FIELD_W-1:0]           field_o,
  output logic [FIELD_W*N_FIELDS-1:0]  clr_mask_o
);
  localparam int W = FIELD_W * N_FIELDS;
  localparam logic [W-1:0] LANE = W'((1 << FIELD_W) - 1);

  logic [W-1:0]       visible;
  logic [FIELD_W-1:0] fld [N_FIELDS];
  logic [W-1:0]       clr [N_FIELDS];

  // reserved position never leaves the unit
  assign visible = cur_i & ~W'(RSV_MASK);

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign fld[g] = visible[g*FIELD_W +: FIELD_W];
    assign clr[g] = W'(EXC_MASK) & (LANE << (g*FIELD_W));
  end

  assign field_o    = fld[fsel_i];
  assign clr_mask_o = clr[fsel_i];

endmodule

// File: rtl/fpstat_wgate.sv
module fpstat_wgate
  import fpstat_pkg::*;
(
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [EXC_W-1:0] exc_i,
  input  logic             inv_en_i,
  input  logic             zdiv_en_i,
  output logic             wr_en_o
);
  logic inv_hit;
  logic zdiv_hit;
  logic blocked;

  always_comb begin
    inv_hit  = (|exc_i[N_INV-1:0]) & inv_en_i;
    zdiv_hit = exc_i[XI_ZDIV] & zdiv_en_i;
    blocked  = inv_hit | zdiv_hit;
    wr_en_o  = 1'b0;
    if (valid_i) begin
      case (upd_op_e'(op_i))
        OP_ARITH: wr_en_o = ~blocked;
        OP_MOVE:  wr_en_o = 1'b1;
        default:  wr_en_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fpstat_next.sv
module fpstat_next
  import fpstat_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [EXC_W-1:0] exc_i,
  input  logic             frac_rnd_i,
  input  logic             frac_inx_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             trivial_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] copy_clr_i,
  output logic [REG_W-1:0] nxt_o
);
  logic [REG_W-1:0] upd;
  logic [EXC_W-1:0] rise;

  always_comb begin
    upd = cur_i;
    case (upd_op_e'(op_i))
      OP_ARITH: begin
        upd[EXC_HI:EXC_LO]     = cur_i[EXC_HI:EXC_LO] | exc_i;
        upd[B_FR]              = frac_rnd_i & ~trivial_i;
        upd[B_FI]              = frac_inx_i & ~trivial_i;
        upd[B_CLS_HI:B_CLS_LO] = cls_i[3:0];
        upd[B_CLS4]            = cls_i[4];
      end
      OP_SETB:  upd[sel_i] = 1'b1;
      OP_CLRB:  upd[sel_i] = 1'b0;
      OP_COPYF: upd = cur_i & ~copy_clr_i;
      default:  upd = cur_i;
    endcase

    // any individual exception going 0->1 raises the overall summary
    rise = upd[EXC_HI:EXC_LO] & ~cur_i[EXC_HI:EXC_LO];
    if (|rise) upd[B_EXC_SUM] = 1'b1;

    upd[B_INV_SUM] = |upd[B_INV_HI:B_INV_LO];
    upd[B_EN_SUM]  = (upd[B_INV_SUM] & upd[B_INV_EN])
                   | (upd[B_OVF]     & upd[B_OVF_EN])
                   | (upd[B_UNF]     & upd[B_UNF_EN])
                   | (upd[B_ZDIV]    & upd[B_ZDIV_EN])
                   | (upd[B_INX]     & upd[B_INX_EN]);
    upd[B_RSV]     = 1'b0;

    nxt_o = valid_i ? upd : cur_i;
  end

endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
  import fpstat_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int N_FIELDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid_i,
  input  logic [2:0]           upd_op_i,
  input  logic [12:0]          exc_i,
  input  logic                 frac_rnd_i,
  input  logic                 frac_inx_i,
  input  logic [4:0]           cls_i,
  input  logic                 trivial_i,
  input  logic [4:0]           sel_i,
  output logic [31:0]          fps_o,
  output logic                 exc_sum_o,
  output logic                 en_sum_o,
  output logic                 inv_sum_o,
  output logic [FIELD_W-1:0]   cr_field_o,
  output logic                 cr_valid_o,
  output logic                 wr_en_o
);
  localparam int FSEL_W = $clog2(N_FIELDS);

  logic [REG_W-1:0]   st_q;
  logic [REG_W-1:0]   st_d;
  logic [REG_W-1:0]   copy_clr;
  logic [FIELD_W-1:0] field;
  logic               is_copy;

  fpstat_crsel #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_crsel (
    .cur_i      (st_q),
    .fsel_i     (sel_i[FSEL_W-1:0]),
    .field_o    (field),
    .clr_mask_o (copy_clr)
  );

  fpstat_next u_next (
    .cur_i      (st_q),
    .valid_i    (upd_valid_i),
    .op_i       (upd_op_i),
    .exc_i      (exc_i),
    .frac_rnd_i (frac_rnd_i),
    .frac_inx_i (frac_inx_i),
    .cls_i      (cls_i),
    .trivial_i  (trivial_i),
    .sel_i      (sel_i),
    .copy_clr_i (copy_clr),
    .nxt_o      (st_d)
  );

  fpstat_wgate u_wgate (
    .valid_i   (upd_valid_i),
    .op_i      (upd_op_i),
    .exc_i     (exc_i),
    .inv_en_i  (st_q[B_INV_EN]),
    .zdiv_en_i (st_q[B_ZDIV_EN]),
    .wr_en_o   (wr_en_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign is_copy    = upd_valid_i && (upd_op_e'(upd_op_i) == OP_COPYF);
  assign cr_valid_o = is_copy;
  assign cr_field_o = is_copy ? field : '0;
  assign fps_o      = st_q;
  assign exc_sum_o  = st_q[B_EXC_SUM];
  assign en_sum_o   = st_q[B_EN_SUM];
  assign inv_sum_o  = st_q[B_INV_SUM];

  AST_RSV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fps_o[B_RSV] == 1'b0); // R6
  AST_INV_SUM_OR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sum_o == |fps_o[B_INV_HI:B_INV_LO]); // R4
  AST_EN_SUM_OR: assert property (@(posedge clk) disable iff (!rst_n)
    en_sum_o == ((fps_o[B_INV_SUM] & fps_o[B_INV_EN]) | (fps_o[B_OVF] & fps_o[B_OVF_EN])
               | (fps_o[B_UNF] & fps_o[B_UNF_EN]) | (fps_o[B_ZDIV] & fps_o[B_ZDIV_EN])
               | (fps_o[B_INX] & fps_o[B_INX_EN]))); // R5
  AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_op_i == 3'd0) |=>
      ((fps_o[EXC_HI:EXC_LO] & $past(fps_o[EXC_HI:EXC_LO])) == $past(fps_o[EXC_HI:EXC_LO]))); // R2
  AST_RISE_SETS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_op_i == 3'd0 && |(exc_i & ~fps_o[EXC_HI:EXC_LO])) |=> exc_sum_o); // R3
  AST_ZDIV_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_op_i == 3'd0 && exc_i[XI_ZDIV] && fps_o[B_ZDIV_EN]) |-> !wr_en_o); // R8
  AST_MOVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_op_i == 3'd1) |=> $stable(fps_o)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid_i |=> $stable(fps_o)); // R13

endmodule

// File: tb/fpstat_unit_bench.sv
module fpstat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid_i = 1'b0;
  logic [2:0]  upd_op_i = '0;
  logic [12:0] exc_i = '0;
  logic        frac_rnd_i = 1'b0;
  logic        frac_inx_i = 1'b0;
  logic [4:0]  cls_i = '0;
  logic        trivial_i = 1'b0;
  logic [4:0]  sel_i = '0;
  logic [31:0] fps_o;
  logic        exc_sum_o, en_sum_o, inv_sum_o;
  logic [3:0]  cr_field_o;
  logic        cr_valid_o, wr_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpstat_unit u_fpstat_unit (
    .clk(clk), .rst_n(rst_n), .upd_valid_i(upd_valid_i), .upd_op_i(upd_op_i),
    .exc_i(exc_i), .frac_rnd_i(frac_rnd_i), .frac_inx_i(frac_inx_i), .cls_i(cls_i),
    .trivial_i(trivial_i), .sel_i(sel_i), .fps_o(fps_o), .exc_sum_o(exc_sum_o),
    .en_sum_o(en_sum_o), .inv_sum_o(inv_sum_o), .cr_field_o(cr_field_o),
    .cr_valid_o(cr_valid_o), .wr_en_o(wr_en_o)
  );

  // {op, exc, frnd, finx, cls, trivial, sel, exp_wen, exp_cr, exp_fps}
  localparam int NV = 19;
  localparam logic [65:0] VEC [NV] = '{
    {3'd0, 13'h0200, 1'b1, 1'b1, 5'h04, 1'b0, 5'd0,  1'b1, 4'h0, 32'h8200_4C00},
    {3'd3, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd31, 1'b0, 4'h0, 32'h0200_4C00},
    {3'd0, 13'h0200, 1'b0, 1'b1, 5'h00, 1'b0, 5'd0,  1'b1, 4'h0, 32'h0200_0400},
    {3'd2, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd7,  1'b0, 4'h0, 32'h0200_0480},
    {3'd2, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd4,  1'b0, 4'h0, 32'h0200_0490},
    {3'd0, 13'h0400, 1'b1, 1'b1, 5'h00, 1'b1, 5'd0,  1'b0, 4'h0, 32'hC600_0090},
    {3'd1, 13'h0100, 1'b1, 1'b1, 5'h1F, 1'b0, 5'd0,  1'b1, 4'h0, 32'hC600_0090},
    {3'd0, 13'h0002, 1'b0, 1'b0, 5'h10, 1'b0, 5'd0,  1'b0, 4'h0, 32'hE602_0190},
    {3'd2, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd9,  1'b0, 4'h0, 32'hE602_0190},
    {3'd4, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd7,  1'b0, 4'hE, 32'h6602_0190},
    {3'd4, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd2,  1'b0, 4'h1, 32'h6602_0190},
    {3'd4, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd6,  1'b0, 4'h6, 32'h6002_0190},
    {3'd3, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd17, 1'b0, 4'h0, 32'h0000_0190},
    {3'd2, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd18, 1'b0, 4'h0, 32'hE004_0190},
    {3'd3, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd31, 1'b0, 4'h0, 32'h6004_0190},
    {3'd2, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd18, 1'b0, 4'h0, 32'h6004_0190},
    {3'd0, 13'h1000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd0,  1'b1, 4'h0, 32'hF004_0090},
    {3'd5, 13'h1FFF, 1'b1, 1'b1, 5'h1F, 1'b0, 5'd0,  1'b0, 4'h0, 32'hF004_0090},
    {3'd3, 13'h0000, 1'b0, 1'b0, 5'h00, 1'b0, 5'd30, 1'b0, 4'h0, 32'hF004_0090}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    // R1: reset state
    #5;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset fps", fps_o, 32'h0);
    chk("R1 reset wr_en", {31'd0, wr_en_o}, 32'd0);
    chk("R1 reset cr_valid", {31'd0, cr_valid_o}, 32'd0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13
    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      v = VEC[i];
      upd_valid_i = 1'b1;
      upd_op_i    = v[65:63];
      exc_i       = v[62:50];
      frac_rnd_i  = v[49];
      frac_inx_i  = v[48];
      cls_i       = v[47:43];
      trivial_i   = v[42];
      sel_i       = v[41:37];
      #5;
      chk($sformatf("R8 R9 R13 wr_en vec %0d", i), {31'd0, wr_en_o}, {31'd0, v[36]});
      chk($sformatf("R7 R13 cr_valid vec %0d", i), {31'd0, cr_valid_o},
          {31'd0, (v[65:63] == 3'd4)});
      if (v[65:63] == 3'd4)
        chk($sformatf("R7 cr_field vec %0d", i), {28'd0, cr_field_o}, {28'd0, v[35:32]});
      @(negedge clk);
      upd_valid_i = 1'b0;
      chk($sformatf("R2 R3 R4 R5 R6 R10 R11 R12 fps vec %0d", i), fps_o, v[31:0]);
      chk($sformatf("R3 R4 R5 summaries vec %0d", i),
          {29'd0, exc_sum_o, en_sum_o, inv_sum_o}, {29'd0, v[31:29]});
    end

    // R13: invalid strobe low with a loud payload
    upd_op_i = 3'd0; exc_i = 13'h1FFF; frac_rnd_i = 1'b1; cls_i = 5'h1F; sel_i = 5'd31;
    #5;
    chk("R13 idle wr_en", {31'd0, wr_en_o}, 32'd0);
    @(negedge clk);
    chk("R13 idle fps", fps_o, 32'hF004_0090);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    #5;
    chk("R1 async reset fps", fps_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset fps", fps_o, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule